// File: doc/BRIEF.md
# Reset Source Classifier and Sequencer

This block sits between a chip's reset sources and its core. It watches an active-low board reset pin, a software reset strobe, a watchdog overflow strobe and a power-on detect input. It decides which kind of reset took place and drives an internal reset of known length. It also drives a board-level reset output that the firmware releases once start-up has finished. A mode input selects how the reset pin is treated. When the mode input is low the pin resets the core directly and at once. When it is high the pin goes through a synchroniser and the block measures how long the pulse lasts.

Each reset leaves a mark in a five-bit cause register that firmware reads during start-up. The marks nest: a stronger reset also sets the flags of every weaker reset below it. The flags accumulate until firmware signals the end of initialisation. The watchdog flag follows its own clearing rules. Time is counted in clock cycles. The pulse thresholds and the sequence length are parameters.

Top module: `rst_src_seq`

## Requirements
- R1: With `sync_mode_i` low, a low level on `ext_rst_n_i` drives `int_rst_o` and `ext_rst_o` high in the same cycle, with no clock edge needed. `int_rst_o` falls as soon as the pin rises again. Each clock edge seen during such a pulse sets the long-hardware, short-hardware and software flags.
- R2: With `sync_mode_i` high, the pin passes through SYNC_STAGES flops. A pulse of N cycles with SHORT_MIN < N < LONG_TICKS is a short hardware reset. It sets cause bits 1 and 0. With two stages, `int_rst_o` is high for exactly N + SEQ_TICKS - 4 cycles: it rises once the measured width passes SHORT_MIN and stays high until SEQ_TICKS cycles after the release is seen.
- R3: A synchronous pulse of LONG_TICKS cycles or more is a long hardware reset. It sets cause bits 2, 1 and 0. The width counter saturates at LONG_TICKS, so a longer pulse still follows the N + SEQ_TICKS - 4 length rule.
- R4: A synchronous pulse of SHORT_MIN cycles or fewer has no effect. `int_rst_o` stays low, `ext_rst_o` stays low and the cause register does not change.
- R5: If `sync_mode_i` falls while the synchronised pin is still low, `int_rst_o` is high in that same cycle and the reset is handled as in R1.
- R6: A `sw_rst_i` strobe drives `int_rst_o` high for exactly SEQ_TICKS cycles, starting at the next clock edge. It sets only cause bit 0.
- R7: A `wdt_ovf_i` strobe drives `int_rst_o` high for exactly SEQ_TICKS cycles. It sets only cause bit 4.
- R8: `ext_rst_o` rises on the first clock edge at which any reset is recognised, and at once in the case of R1. It stays high until `init_done_i` is sampled while `int_rst_o` is low. An `init_done_i` sampled while `int_rst_o` is high is ignored.
- R9: An accepted `init_done_i` clears cause bits 3, 2, 1 and 0 and leaves bit 4 unchanged.
- R10: Cause bit 4 is cleared by `wdt_srv_i` or by any hardware reset (R1, R2, R3). When a set and a clear of the same bit occur in one cycle, the set wins.
- R11: While `por_i` is high, all state resets asynchronously. The cause register reads 5'b01111, `ext_rst_o` is high and `int_rst_o` is high. `int_rst_o` then stays high through a SEQ_TICKS sequence after `por_i` falls.
- R12: `sw_rst_i` and `wdt_ovf_i` strobes that arrive while `int_rst_o` is high are ignored. They do not set flags and do not extend the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock; one cycle is one tick |
| por_i | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n_i | input | 1 | Board reset pin, active low |
| sync_mode_i | input | 1 | 1: synchronous measured reset, 0: asynchronous reset |
| sw_rst_i | input | 1 | Software reset strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| wdt_srv_i | input | 1 | Watchdog service strobe, clears the watchdog flag |
| init_done_i | input | 1 | End-of-initialisation strobe |
| int_rst_o | output | 1 | Internal core reset, active high |
| ext_rst_o | output | 1 | Board-level reset output, active high |
| cause_o | output | 5 | Cause flags: [0] software, [1] short hw, [2] long hw, [3] power-on, [4] watchdog |

## Verification
The bench builds the block with SHORT_MIN = 4, LONG_TICKS = 24, SEQ_TICKS = 16 and two synchroniser stages. With these values every class boundary can be reached within a few dozen cycles. The bench drives pulses of 4, 5, 23, 24 and 60 cycles, which covers the glitch limit, both edges of the short window, the long threshold and counter saturation. The short sequence also makes it cheap to inject strobes in the middle of a running sequence and to switch modes halfway through a pulse.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int unsigned CAUSE_W = 5;
   localparam int unsigned C_SW    = 0;
   localparam int unsigned C_HWS   = 1;
   localparam int unsigned C_HWL   = 2;
   localparam int unsigned C_PWR   = 3;
   localparam int unsigned C_DOG   = 4;
   typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rst_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) stage_q <= '1;
      else       stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rst_width_meter.sv
module rst_width_meter #(
   parameter int unsigned SHORT_MIN  = 4,
   parameter int unsigned LONG_TICKS = 1032
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic sync_mode_i,
   input  logic pin_n_i,
   output logic pend_o,
   output logic short_ev_o,
   output logic long_ev_o
);
   localparam int unsigned CW = $clog2(LONG_TICKS + 1);
   localparam logic [CW-1:0] MIN_C  = CW'(SHORT_MIN);
   localparam logic [CW-1:0] LONG_C = CW'(LONG_TICKS);

   generate
      if (LONG_TICKS <= SHORT_MIN + 1) begin : g_bad_window
         $error("rst_width_meter: LONG_TICKS must exceed SHORT_MIN + 1");
      end
   endgenerate

   logic [CW-1:0] width_q;
   logic          release_w;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)                 width_q <= '0;
      else if (!sync_mode_i)     width_q <= '0;
      else if (!pin_n_i)         width_q <= (width_q == LONG_C) ? width_q : width_q + 1'b1;
      else                       width_q <= '0;
   end

   assign pend_o     = sync_mode_i && (width_q > MIN_C);
   assign release_w  = pend_o && pin_n_i;
   assign short_ev_o = release_w && (width_q <  LONG_C);
   assign long_ev_o  = release_w && (width_q == LONG_C);

   // R3: once saturated, a held pin keeps the counter at the limit
   assert_sat_hold_R3: assert property (@(posedge clk_i) disable iff (por_i)
      (width_q == LONG_C && !pin_n_i && sync_mode_i) |=> (width_q == LONG_C));

   // R5: leaving synchronous mode discards the measured width
   assert_mode_drop_R5: assert property (@(posedge clk_i) disable iff (por_i)
      (!sync_mode_i) |=> (width_q == '0));
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
   parameter int unsigned SEQ_TICKS = 1024
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic start_i,
   output logic active_o
);
   localparam int unsigned SW = $clog2(SEQ_TICKS + 1);
   localparam logic [SW-1:0] SEQ_C = SW'(SEQ_TICKS);

   generate
      if (SEQ_TICKS < 2) begin : g_bad_len
         $error("rst_seq_timer: SEQ_TICKS must be at least 2");
      end
   endgenerate

   logic [SW-1:0] left_q;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)               left_q <= SEQ_C;
      else if (start_i)        left_q <= SEQ_C;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign active_o = (left_q != '0);

   // R6: a start loads the full sequence length
   assert_seq_load_R6: assert property (@(posedge clk_i) disable iff (por_i)
      start_i |=> (left_q == SEQ_C));

   // R7: the last tick of a sequence ends the internal reset
   assert_seq_end_R7: assert property (@(posedge clk_i) disable iff (por_i)
      (left_q == SW'(1) && !start_i) |=> !active_o);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rstseq_pkg::*;
(
   input  logic   clk_i,
   input  logic   por_i,
   input  logic   ev_sw_i,
   input  logic   ev_hws_i,
   input  logic   ev_hwl_i,
   input  logic   ev_dog_i,
   input  logic   clr_init_i,
   input  logic   clr_dog_i,
   output cause_t cause_o
);
   cause_t flags_q;
   logic   hw_w;

   assign hw_w = ev_hws_i || ev_hwl_i;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         flags_q        <= '0;
         flags_q[C_SW]  <= 1'b1;
         flags_q[C_HWS] <= 1'b1;
         flags_q[C_HWL] <= 1'b1;
         flags_q[C_PWR] <= 1'b1;
      end else begin
         if (ev_sw_i || hw_w)  flags_q[C_SW]  <= 1'b1;
         else if (clr_init_i)  flags_q[C_SW]  <= 1'b0;
         if (hw_w)             flags_q[C_HWS] <= 1'b1;
         else if (clr_init_i)  flags_q[C_HWS] <= 1'b0;
         if (ev_hwl_i)         flags_q[C_HWL] <= 1'b1;
         else if (clr_init_i)  flags_q[C_HWL] <= 1'b0;
         if (clr_init_i)       flags_q[C_PWR] <= 1'b0;
         if (ev_dog_i)                 flags_q[C_DOG] <= 1'b1;
         else if (clr_dog_i || hw_w)   flags_q[C_DOG] <= 1'b0;
      end
   end

   assign cause_o = flags_q;

   // R9: accepted init-done clears the nested flags
   assert_init_clear_R9: assert property (@(posedge clk_i) disable iff (por_i)
      (clr_init_i && !ev_sw_i && !hw_w) |=> (flags_q[C_HWL:C_SW] == '0 && !flags_q[C_PWR]));

   // R9: init-done leaves the watchdog flag alone
   assert_dog_keep_R9: assert property (@(posedge clk_i) disable iff (por_i)
      (clr_init_i && !clr_dog_i && !hw_w && flags_q[C_DOG]) |=> flags_q[C_DOG]);

   // R10: a service strobe clears the watchdog flag unless it is set again
   assert_dog_srv_R10: assert property (@(posedge clk_i) disable iff (por_i)
      (clr_dog_i && !ev_dog_i) |=> !flags_q[C_DOG]);
endmodule

// File: rtl/rst_src_seq.sv
module rst_src_seq
   import rstseq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SHORT_MIN   = 4,
   parameter int unsigned LONG_TICKS  = 1032,
   parameter int unsigned SEQ_TICKS   = 1024
) (
   input  logic               clk_i,
   input  logic               por_i,
   input  logic               ext_rst_n_i,
   input  logic               sync_mode_i,
   input  logic               sw_rst_i,
   input  logic               wdt_ovf_i,
   input  logic               wdt_srv_i,
   input  logic               init_done_i,
   output logic               int_rst_o,
   output logic               ext_rst_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic pin_s;
   logic pend_w, short_ev_w, long_ev_w;
   logic async_now_w, seq_active_w, seq_start_w;
   logic sw_ev_w, dog_ev_w, init_ok_w, ext_q;

   rst_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .por_i (por_i), .d_i (ext_rst_n_i), .q_o (pin_s)
   );

   rst_width_meter #(.SHORT_MIN(SHORT_MIN), .LONG_TICKS(LONG_TICKS)) u_meter (
      .clk_i (clk_i), .por_i (por_i), .sync_mode_i (sync_mode_i), .pin_n_i (pin_s),
      .pend_o (pend_w), .short_ev_o (short_ev_w), .long_ev_o (long_ev_w)
   );

   assign async_now_w = !sync_mode_i && !ext_rst_n_i;
   assign int_rst_o   = async_now_w || pend_w || seq_active_w;
   assign sw_ev_w     = sw_rst_i  && !int_rst_o;
   assign dog_ev_w    = wdt_ovf_i && !int_rst_o;
   assign init_ok_w   = init_done_i && !int_rst_o;
   assign seq_start_w = sw_ev_w || dog_ev_w || short_ev_w || long_ev_w;

   rst_seq_timer #(.SEQ_TICKS(SEQ_TICKS)) u_timer (
      .clk_i (clk_i), .por_i (por_i), .start_i (seq_start_w), .active_o (seq_active_w)
   );

   rst_cause_reg u_cause (
      .clk_i      (clk_i),
      .por_i      (por_i),
      .ev_sw_i    (sw_ev_w),
      .ev_hws_i   (short_ev_w),
      .ev_hwl_i   (long_ev_w || async_now_w),
      .ev_dog_i   (dog_ev_w),
      .clr_init_i (init_ok_w),
      .clr_dog_i  (wdt_srv_i),
      .cause_o    (cause_o)
   );

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)                                            ext_q <= 1'b1;
      else if (async_now_w || pend_w || sw_ev_w || dog_ev_w) ext_q <= 1'b1;
      else if (init_ok_w)                                   ext_q <= 1'b0;
   end

   assign ext_rst_o = ext_q || async_now_w;

   // R8: the board reset holds until an accepted init-done
   assert_ext_hold_R8: assert property (@(posedge clk_i) disable iff (por_i)
      (ext_rst_o && !init_ok_w) |=> ext_rst_o);

   // R12: strobes during an active internal reset never restart the sequence
   assert_strobe_ignored_R12: assert property (@(posedge clk_i) disable iff (por_i)
      (seq_active_w && !pend_w && !short_ev_w && !long_ev_w) |-> !seq_start_w);
endmodule

// File: tb/test_rst_src_seq.sv
module test_rst_src_seq;
   import rstseq_pkg::*;

   localparam int unsigned P_MIN  = 4;
   localparam int unsigned P_LONG = 24;
   localparam int unsigned P_SEQ  = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por, ext_n, mode, sw, wdt, srv, idone;
   logic int_rst, ext_rst;
   logic [CAUSE_W-1:0] cause;

   rst_src_seq #(.SYNC_STAGES(2), .SHORT_MIN(P_MIN), .LONG_TICKS(P_LONG), .SEQ_TICKS(P_SEQ))
   i_rst_src_seq (
      .clk_i (clk), .por_i (por), .ext_rst_n_i (ext_n), .sync_mode_i (mode),
      .sw_rst_i (sw), .wdt_ovf_i (wdt), .wdt_srv_i (srv), .init_done_i (idone),
      .int_rst_o (int_rst), .ext_rst_o (ext_rst), .cause_o (cause)
   );

   typedef struct {
      int     len;
      cause_t flags;
      string  req;
   } item_t;

   item_t q[$];
   int    total = 0;
   int    bad   = 0;
   bit    saw_int = 1'b0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // monitor: measures each internal reset pulse and compares with the queue
   initial begin
      int   len;
      logic prev;
      len  = 0;
      prev = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         if (int_rst) begin
            len++;
            saw_int = 1'b1;
         end else if (prev) begin
            if (q.size() == 0) begin
               chk(1'b0, "R4", "unexpected internal reset", len, 0);
            end else begin
               item_t it;
               it = q.pop_front();
               if (it.len >= 0) chk(len == it.len, it.req, "reset length", len, it.len);
               chk(cause == it.flags, it.req, "cause flags", int'(cause), int'(it.flags));
            end
            len = 0;
         end
         prev = int_rst;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      report();
      $finish;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_item(input int len, input cause_t f, input string r);
      item_t it;
      it.len = len; it.flags = f; it.req = r;
      q.push_back(it);
   endtask

   task automatic settle;
      do @(negedge clk); while (int_rst);
      cyc(2);
   endtask

   task automatic init_pulse;
      @(negedge clk) idone = 1'b1;
      @(negedge clk) idone = 1'b0;
   endtask

   task automatic strobe_wdt;
      @(negedge clk) wdt = 1'b1;
      @(negedge clk) wdt = 1'b0;
   endtask

   task automatic sync_pulse(input int n);
      @(negedge clk) ext_n = 1'b0;
      cyc(n);
      ext_n = 1'b1;
      cyc(4);
   endtask

   initial begin
      por = 1'b1; ext_n = 1'b1; mode = 1'b1;
      sw = 1'b0; wdt = 1'b0; srv = 1'b0; idone = 1'b0;
      expect_item(-1, 5'b01111, "R11");
      @(posedge clk); #1;
      chk(cause == 5'b01111, "R11", "power-on flags", int'(cause), 15);
      chk(ext_rst && int_rst, "R11", "resets during power-on", {ext_rst, int_rst}, 3);
      cyc(3);
      por = 1'b0;
      settle();
      chk(ext_rst == 1'b1, "R8", "board reset held after sequence", ext_rst, 1);
      init_pulse();
      chk(ext_rst == 1'b0, "R8", "board reset after init-done", ext_rst, 0);
      chk(cause == 5'b00000, "R9", "flags after init-done", int'(cause), 0);

      // software reset, with ignored strobes during its sequence
      expect_item(P_SEQ, 5'b00001, "R6");
      @(negedge clk) sw = 1'b1;
      @(negedge clk) sw = 1'b0;
      chk(ext_rst && int_rst, "R8", "board reset on software strobe", {ext_rst, int_rst}, 3);
      cyc(3);
      sw = 1'b1; wdt = 1'b1;
      @(negedge clk) begin sw = 1'b0; wdt = 1'b0; idone = 1'b1; end
      @(negedge clk) idone = 1'b0;
      settle();
      chk(ext_rst == 1'b1, "R8", "init-done during reset ignored", ext_rst, 1);
      chk(cause == 5'b00001, "R12", "strobes in sequence ignored", int'(cause), 1);
      init_pulse();

      // watchdog reset and its separate flag rules
      expect_item(P_SEQ, 5'b10000, "R7");
      strobe_wdt();
      settle();
      init_pulse();
      chk(cause == 5'b10000, "R9", "watchdog flag survives init-done", int'(cause), 16);
      chk(ext_rst == 1'b0, "R8", "board reset released", ext_rst, 0);
      @(negedge clk) srv = 1'b1;
      @(negedge clk) srv = 1'b0;
      chk(cause == 5'b00000, "R10", "service clears watchdog flag", int'(cause), 0);

      expect_item(P_SEQ, 5'b10000, "R7");
      strobe_wdt();
      settle();
      init_pulse();

      // synchronous pulses: short window edges, glitch, long, saturation
      expect_item(5 + P_SEQ - 4, 5'b00011, "R2");
      sync_pulse(5);
      settle();
      chk(cause == 5'b00011, "R10", "hardware reset clears watchdog flag", int'(cause), 3);
      init_pulse();

      saw_int = 1'b0;
      sync_pulse(4);
      cyc(4);
      chk(!saw_int, "R4", "glitch raised internal reset", saw_int, 0);
      chk(ext_rst == 1'b0, "R4", "glitch raised board reset", ext_rst, 0);
      chk(cause == 5'b00000, "R4", "glitch changed flags", int'(cause), 0);

      expect_item(23 + P_SEQ - 4, 5'b00011, "R2");
      sync_pulse(23);
      settle();
      init_pulse();

      expect_item(24 + P_SEQ - 4, 5'b00111, "R3");
      sync_pulse(24);
      settle();
      init_pulse();

      expect_item(60 + P_SEQ - 4, 5'b00111, "R3");
      sync_pulse(60);
      settle();
      init_pulse();

      // asynchronous mode
      mode = 1'b0;
      expect_item(10, 5'b00111, "R1");
      @(negedge clk) ext_n = 1'b0;
      #1;
      chk(int_rst && ext_rst, "R1", "immediate reset in async mode", {int_rst, ext_rst}, 3);
      cyc(10);
      ext_n = 1'b1;
      #1;
      chk(int_rst == 1'b0, "R1", "release follows pin", int_rst, 0);
      settle();
      init_pulse();
      mode = 1'b1;
      cyc(4);

      // mode drop in the middle of a synchronous pulse
      expect_item(-1, 5'b00111, "R5");
      @(negedge clk) ext_n = 1'b0;
      cyc(3);
      chk(int_rst == 1'b0, "R5", "no reset before qualification", int_rst, 0);
      mode = 1'b0;
      #1;
      chk(int_rst == 1'b1, "R5", "immediate reset on mode drop", int_rst, 1);
      cyc(5);
      ext_n = 1'b1;
      #1;
      chk(int_rst == 1'b0, "R5", "release after mode drop", int_rst, 0);
      cyc(4);
      mode = 1'b1;
      settle();
      init_pulse();
      cyc(2);
      chk(q.size() == 0, "R2", "expected resets left unseen", q.size(), 0);

      report();
      $finish;
   end
endmodule